// File: doc/BRIEF.md
# Dual-Timer PWM Generator

A bus-mapped peripheral that produces one active-high pulse-width-modulated output from two down-counting reload timers. Timer 0 sets the period and timer 1 sets the high time. Each timer has three word registers: a control/status word, a load value and a read-only live count. Software reaches them through a plain synchronous bus with an address, write data, a write strobe and combinational read data.

To run a waveform, software first stops both timers and writes both load values. It then pulses each timer's load bit to copy the load value into the counter. Last, it sets the enable-all bit, which starts both timers on the same edge so they stay phase-aligned. Enabling only one timer holds the output at a fixed level. Each timer raises a sticky status flag when it expires while its generate bit is set.

Top module: `dual_tmr_pwm`

## Requirements
- R1: `addr_i[4]` selects the timer (0 or 1). `addr_i[3:2]` selects the register: 0 is control, 1 is load, 2 is count. Writes to the count register, to the unused register slot and to addresses with `addr_i[1:0]` nonzero have no effect. Reads return the selected register, zero-extended.
- R2: While control bit 5 (load) is set, the counter holds the load value and does not count, even if the timer is enabled.
- R3: Writing control bit 10 (enable-all) to either timer sets control bit 7 (run) of both timers on the same edge.
- R4: PWM mode needs control bits 1, 2, 4 and 9 set in both timers. With both timers running in PWM mode, the output repeats every load0 + 2 cycles.
- R5: In PWM mode with both timers running, the output is high from the start of each period for load1 + 2 cycles. The first period starts in the cycle after enable-all is written.
- R6: When load1 equals load0, the end of the high time and the period boundary fall in the same cycle. The boundary wins and the output stays high with no falling edge.
- R7: In PWM mode, the output is constant 1 when only timer 0 runs and constant 0 when only timer 1 runs.
- R8: Clearing a run bit stops that counter at its current value. The output is 0 when neither timer runs.
- R9: Control bit 8 is set when the timer expires while bit 2 (generate) is set. Writing 1 to bit 8 clears it.
- R10: After reset, all registers read 0 and the output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe, one cycle per write |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| pwm_o | output | 1 | PWM output, active high |

## Verification
Two events can land on the same edge: the end of timer 0's period and the end of timer 1's high time. The first sets the output and the second clears it. The bench provokes the collision by giving both timers the same load value. It judges the result by counting high samples and rising edges over three periods: all samples must be high and there must be no rising edge. Neighbouring vectors with the high time one or more cycles shorter than the period show that the clear still works whenever the two events are apart.

// File: rtl/pwm2t_pkg.sv
package pwm2t_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;
  localparam int CTL_W  = 12;
  // control bit positions, decoded by software
  localparam int B_MODE = 0;
  localparam int B_DOWN = 1;
  localparam int B_GEN  = 2;
  localparam int B_CAPT = 3;
  localparam int B_ARLD = 4;
  localparam int B_LOAD = 5;
  localparam int B_IEN  = 6;
  localparam int B_RUN  = 7;
  localparam int B_FLAG = 8;
  localparam int B_PWM  = 9;
  localparam int B_ALL  = 10;
  localparam int B_CASC = 11;

  typedef enum logic [1:0] {
    REG_CTL  = 2'd0,
    REG_LOAD = 2'd1,
    REG_CNT  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pwm2t_timer.sv
module pwm2t_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic             sync_i,
  input  logic             arld_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic pend_q, done_q, live;

  assign live     = en_i & ~done_q & ~load_i & ~sync_i;
  assign expire_o = live & pend_q;
  assign cnt_o    = cnt_q;

  // zero is held one extra cycle (pend) so a period spans load + 2
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else if (load_i || sync_i) begin
      cnt_q  <= load_val_i;
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else if (live) begin
      if (pend_q) begin
        pend_q <= 1'b0;
        if (arld_i) cnt_q <= load_val_i;
        else        done_q <= 1'b1;
      end else if (cnt_q == '0) begin
        pend_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  p_load_copy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_o == $past(load_val_i)))
    else $error("load bit did not copy load value");

  p_stop_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i && !sync_i) |=> $stable(cnt_o))
    else $error("stopped counter moved");
endmodule

// File: rtl/pwm2t_csr.sv
module pwm2t_csr
  import pwm2t_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic                        we_i,
  input  logic [1:0][CNT_W-1:0]       cnt_i,
  input  logic [1:0]                  expire_i,
  output logic [1:0][CTL_W-1:0]       ctl_o,
  output logic [1:0][CNT_W-1:0]       load_o,
  output logic [DATA_W-1:0]           rdata_o
);
  reg_sel_e sel;
  logic     aligned, wr, all_req;

  assign sel     = reg_sel_e'(addr_i[3:2]);
  assign aligned = (addr_i[1:0] == 2'b00);
  assign wr      = we_i & aligned;
  assign all_req = wr & (sel == REG_CTL) & wdata_i[B_ALL];

  for (genvar t = 0; t < 2; t++) begin : g_tmr
    logic [CTL_W-1:0] ctl_q;
    logic [CNT_W-1:0] ld_q;
    logic             hit;

    assign hit = wr & (addr_i[4] == 1'(t));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctl_q <= '0;
        ld_q  <= '0;
      end else begin
        if (hit && sel == REG_CTL) begin
          ctl_q         <= wdata_i[CTL_W-1:0];
          ctl_q[B_RUN]  <= wdata_i[B_RUN] | wdata_i[B_ALL];
          ctl_q[B_FLAG] <= ctl_q[B_FLAG] & ~wdata_i[B_FLAG];
        end else if (all_req) begin
          ctl_q[B_RUN]  <= 1'b1;
        end
        // set wins over a same-cycle clear
        if (expire_i[t] && ctl_q[B_GEN]) ctl_q[B_FLAG] <= 1'b1;
        if (hit && sel == REG_LOAD) ld_q <= wdata_i[CNT_W-1:0];
      end
    end

    assign ctl_o[t]  = ctl_q;
    assign load_o[t] = ld_q;
  end

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      case (sel)
        REG_CTL:  rdata_o = DATA_W'(ctl_o[addr_i[4]]);
        REG_LOAD: rdata_o = DATA_W'(load_o[addr_i[4]]);
        REG_CNT:  rdata_o = DATA_W'(cnt_i[addr_i[4]]);
        default:  rdata_o = '0;
      endcase
    end
  end

  p_enall_both_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_req |=> (ctl_o[0][B_RUN] && ctl_o[1][B_RUN]))
    else $error("enable-all did not start both timers");

  p_flag_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i[0] && ctl_o[0][B_GEN]) |=> ctl_o[0][B_FLAG])
    else $error("expiry flag not raised");
endmodule

// File: rtl/pwm2t_wave.sv
module pwm2t_wave (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] run_i,
  input  logic       pwm_mode_i,
  input  logic       exp0_i,
  input  logic       exp1_i,
  output logic       pwm_o
);
  logic both, both_q, start, hi_q;

  assign both  = &run_i;
  assign start = both & ~both_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      both_q <= 1'b0;
      hi_q   <= 1'b0;
    end else begin
      both_q <= both;
      if (start || exp0_i) hi_q <= 1'b1;  // period boundary beats high-time end
      else if (exp1_i)     hi_q <= 1'b0;
    end
  end

  always_comb begin
    pwm_o = 1'b0;
    if (pwm_mode_i) begin
      case (run_i)
        2'b11:   pwm_o = hi_q | start;
        2'b01:   pwm_o = 1'b1;
        default: pwm_o = 1'b0;
      endcase
    end
  end

  p_rise_at_boundary_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (both && pwm_mode_i && exp0_i) |=> (!(&run_i) || !pwm_mode_i || pwm_o))
    else $error("output not high after period boundary");

  p_fall_at_expiry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (both && pwm_mode_i && exp1_i && !exp0_i) |=> (!(&run_i) || !pwm_mode_i || !pwm_o))
    else $error("output not low after high time");
endmodule

// File: rtl/dual_tmr_pwm.sv
module dual_tmr_pwm
  import pwm2t_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [4:0]        addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              we_i,
  output logic [31:0]       rdata_o,
  output logic              pwm_o
);
  logic [1:0][CTL_W-1:0] ctl;
  logic [1:0][CNT_W-1:0] load, cnt;
  logic [1:0]            expire, sync, arld, run;
  logic                  pwm_mode, ctl_unused;

  assign pwm_mode = ctl[0][B_DOWN] & ctl[0][B_GEN] & ctl[0][B_ARLD] & ctl[0][B_PWM]
                  & ctl[1][B_DOWN] & ctl[1][B_GEN] & ctl[1][B_ARLD] & ctl[1][B_PWM];
  assign ctl_unused = ^{ctl[0], ctl[1]};

  // timer 1 waits at zero until timer 0 opens the next period
  assign sync[0] = 1'b0;
  assign sync[1] = expire[0] & pwm_mode & ctl[1][B_RUN];
  assign arld[0] = ctl[0][B_ARLD];
  assign arld[1] = ctl[1][B_ARLD] & ~pwm_mode;

  pwm2t_csr #(.CNT_W(CNT_W)) u_csr (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i,
    .cnt_i(cnt), .expire_i(expire), .ctl_o(ctl), .load_o(load), .rdata_o
  );

  for (genvar t = 0; t < 2; t++) begin : g_tmr
    assign run[t] = ctl[t][B_RUN];
    pwm2t_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk_i, .rst_ni,
      .en_i(ctl[t][B_RUN]), .load_i(ctl[t][B_LOAD]), .sync_i(sync[t]),
      .arld_i(arld[t]), .load_val_i(load[t]),
      .cnt_o(cnt[t]), .expire_o(expire[t])
    );
  end

  pwm2t_wave u_wave (
    .clk_i, .rst_ni, .run_i(run), .pwm_mode_i(pwm_mode),
    .exp0_i(expire[0]), .exp1_i(expire[1]), .pwm_o
  );
endmodule

// File: tb/sim_dual_tmr_pwm.sv
`timescale 1ns/1ps
module sim_dual_tmr_pwm;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] rdata_o;
  logic        pwm_o;
  int checks = 0;
  int fails  = 0;

  localparam logic [31:0] C_PWM  = 32'h216;
  localparam logic [31:0] C_LOAD = 32'h020;
  localparam logic [31:0] C_RUN  = 32'h080;
  localparam logic [31:0] C_FLAG = 32'h100;
  localparam logic [31:0] C_ALL  = 32'h400;

  // {load0, load1, highs over 3 periods, rising edges over 3 periods}
  localparam int VEC [5][4] = '{
    '{8, 3, 15, 2},
    '{5, 0, 6, 2},
    '{4, 4, 18, 0},
    '{1, 0, 6, 2},
    '{20, 10, 36, 2}
  };

  always #4 clk_i = ~clk_i;

  dual_tmr_pwm u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] d, a;
    int highs, rises;
    logic prev, cur;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    rd(5'h00, d); chk("R10 ctl0", d, 0);
    rd(5'h10, d); chk("R10 ctl1", d, 0);
    chk("R10 pwm", pwm_o, 0);

    for (int v = 0; v < 5; v++) begin
      wr(5'h00, C_PWM); wr(5'h10, C_PWM);
      wr(5'h04, VEC[v][0]); wr(5'h00, C_PWM | C_LOAD);
      wr(5'h14, VEC[v][1]); wr(5'h10, C_PWM | C_LOAD);
      wr(5'h00, C_PWM);
      wr(5'h10, C_PWM | C_ALL);
      highs = 0; rises = 0; prev = 1'b0;
      for (int i = 0; i < 3 * (VEC[v][0] + 2); i++) begin
        if (i > 0) @(negedge clk_i);
        cur = pwm_o;
        if (cur) highs++;
        if (i > 0 && cur && !prev) rises++;
        prev = cur;
      end
      chk((VEC[v][0] == VEC[v][1]) ? "R6 high count" : "R5 high count", highs, VEC[v][2]);
      chk((VEC[v][0] == VEC[v][1]) ? "R6 rising edges" : "R4 rising edges", rises, VEC[v][3]);
      rd(5'h00, d); a = d;
      rd(5'h10, d);
      chk("R3 both run bits", {a[7], d[7]}, 2'b11);
      if (v == 0) chk("R9 flag set", a[8], 1);
    end

    wr(5'h00, C_PWM | C_FLAG);  // stop t0 and clear flag
    rd(5'h00, d); chk("R9 flag cleared", d[8], 0);
    chk("R7 only t1 -> low", pwm_o, 0);
    rd(5'h08, a);
    repeat (5) @(negedge clk_i);
    rd(5'h08, d); chk("R8 stopped counter held", d, a);

    wr(5'h10, C_PWM);
    chk("R8 none running -> low", pwm_o, 0);
    wr(5'h00, C_PWM | C_RUN);
    chk("R7 only t0 -> high", pwm_o, 1);
    repeat (7) @(negedge clk_i);
    chk("R7 only t0 stays high", pwm_o, 1);
    wr(5'h00, C_PWM);
    wr(5'h10, C_PWM | C_RUN);
    repeat (3) @(negedge clk_i);
    chk("R7 only t1 -> low", pwm_o, 0);
    wr(5'h10, C_PWM);

    wr(5'h04, 32'd7);
    wr(5'h00, C_PWM | C_LOAD | C_RUN);
    repeat (4) @(negedge clk_i);
    rd(5'h08, d); chk("R2 held at load value", d, 7);
    wr(5'h00, C_PWM | C_RUN);
    repeat (3) @(negedge clk_i);
    rd(5'h08, d); chk("R2 counts after release", d < 7, 1);
    wr(5'h00, C_PWM);

    wr(5'h14, 32'h1234_5678);
    rd(5'h14, d); chk("R1 load1 readback", d, 32'h1234_5678);
    rd(5'h04, d); chk("R1 load0 untouched", d, 7);
    rd(5'h18, a);
    wr(5'h18, 32'hFFFF);
    rd(5'h18, d); chk("R1 count read-only", d, a);
    wr(5'h15, 32'h55);
    rd(5'h14, d); chk("R1 misaligned ignored", d, 32'h1234_5678);

    summary();
  end
endmodule